// File: doc/BRIEF.md
# Synaptic Cycle Engine

The engine executes one fixed processing round for a single synaptic node. Its private local memory holds two address tables (one for gather, one for scatter), a table of output weights, a table of output signals and four scalar words. A host pulses `start`. The engine then runs four phases:

1. It gathers shared-memory words through the input address table and sums them into an excitation value.
2. It derives one output signal per weight as excitation times weight divided by a signed factor.
3. It drains those signals out of the excitation.
4. It scatters the signals to shared memory through the output address table.

The final excitation is then stored back, and `done` pulses.

The local memory is single-ported with one cycle of read latency. The shared-memory port is a request/ready pair. A read returns its data in the cycle that `sm_ready` is high, and a write is taken in that same cycle. The division is a restoring divider on signed 64-bit products, which produces one quotient bit per clock.

Top module: `synapse_engine`

## Requirements
- R1: While reset is asserted and after it is released, `done`, `div_err`, `sm_req` and `lm_we` are 0 until a run is started.
- R2: With K = LM_WORDS/5, local memory is laid out as follows. Word K*r+i is entry i of table r, where r=0 is the gather addresses, r=1 the scatter addresses, r=2 the signals and r=3 the weights. Word 4K holds the excitation, 4K+1 the factor, 4K+2 the gather count and 4K+3 the scatter count.
- R3: Phase 1 issues exactly one shared-memory read per gather entry i below the gather count, and adds each returned word into the excitation modulo 2^32.
- R4: Phase 2 stores signal i for every i below the scatter count. The value is the signed 64-bit product of the phase-1 excitation and weight i, divided by the factor and truncated toward zero, keeping the low 32 bits.
- R5: After phase 3, the word at 4K equals the phase-1 excitation minus the sum of the stored signals, modulo 2^32.
- R6: Phase 4 writes signal i to the shared address held in scatter entry i, one write per entry, in ascending i.
- R7: A zero factor stores every signal as 0 and sets `div_err`. `div_err` then stays 1 until reset.
- R8: A zero gather count skips phase 1 with no shared reads. A zero scatter count skips phases 2 to 4 with no signal or shared writes. The excitation is still stored.
- R9: `done` is high for exactly one clock per run, after the excitation store. `start` has no effect while a run is in progress.
- R10: A shared-memory request that is not granted stays asserted the next clock with the same address, direction and write data.
- R11: The engine writes local memory only at signal entries below the scatter count and at word 4K.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the engine is idle |
| done | output | 1 | One-clock pulse at the end of a run |
| div_err | output | 1 | Sticky flag: a signal was computed with a zero factor |
| lm_addr | output | $clog2(LM_WORDS) | Local memory word address |
| lm_we | output | 1 | Local memory write strobe |
| lm_wdata | output | 32 | Local memory write data |
| lm_rdata | input | 32 | Local memory read data, one clock after the address |
| sm_req | output | 1 | Shared memory request |
| sm_we | output | 1 | Request is a write (1) or read (0) |
| sm_addr | output | SM_AW | Shared memory word address |
| sm_wdata | output | 32 | Shared memory write data |
| sm_rdata | input | 32 | Shared memory read data, valid with `sm_ready` |
| sm_ready | input | 1 | Shared memory accepts the request this clock |

## Verification
The assertions presume that the gather and scatter counts stored at 4K+2 and 4K+3 are below K, and that local memory answers every read exactly one clock after the address. The stimulus keeps within these limits. Each count is drawn from 0 to K-1. Every table address points inside a 64-word shared memory model, and a local-memory model always replies with one clock of latency. The ready line is driven either continuously high or at random, so the hold rule on stalled requests is exercised while the counts and factors vary.

// File: rtl/sme_pkg.sv
package sme_pkg;
  localparam int DATA_W = 32;
  localparam int WIDE_W = 2 * DATA_W;

  // Local memory region selector; the numeric value is the region index.
  typedef enum logic [2:0] {
    RG_IN  = 3'd0,
    RG_OUT = 3'd1,
    RG_SIG = 3'd2,
    RG_PER = 3'd3,
    RG_SCL = 3'd4
  } lm_region_e;

  // Scalar slot indices inside the scalar region.
  localparam int SCL_EXC   = 0;
  localparam int SCL_FAC   = 1;
  localparam int SCL_INSZ  = 2;
  localparam int SCL_OUTSZ = 3;
  localparam int SCL_COUNT = 4;

  typedef enum logic [4:0] {
    S_IDLE, S_LDS, S_DISP,
    S_P1_RD, S_P1_ADR, S_P1_SM,
    S_P2_RD, S_P2_MUL, S_P2_DIV, S_P2_WR,
    S_P3_RD, S_P3_ACC,
    S_P4_RA, S_P4_RB, S_P4_CAP, S_P4_SM,
    S_WB, S_DONE
  } eng_state_e;

  function automatic logic [WIDE_W-1:0] wide_mag(input logic [WIDE_W-1:0] v);
    return v[WIDE_W-1] ? (~v + WIDE_W'(1)) : v;
  endfunction

  function automatic logic [DATA_W-1:0] word_mag(input logic [DATA_W-1:0] v);
    return v[DATA_W-1] ? (~v + DATA_W'(1)) : v;
  endfunction

  // Signed 32x32 -> 64 product.
  function automatic logic [WIDE_W-1:0] wide_product(input logic [DATA_W-1:0] a,
                                                     input logic [DATA_W-1:0] b);
    logic signed [WIDE_W-1:0] sa;
    logic signed [WIDE_W-1:0] sb;
    sa = {{DATA_W{a[DATA_W-1]}}, a};
    sb = {{DATA_W{b[DATA_W-1]}}, b};
    return sa * sb;
  endfunction

  // Applies the quotient sign to a magnitude and keeps the low word.
  function automatic logic [DATA_W-1:0] quot_fold(input logic [WIDE_W-1:0] m,
                                                  input logic neg);
    logic [WIDE_W-1:0] s;
    s = neg ? (~m + WIDE_W'(1)) : m;
    return s[DATA_W-1:0];
  endfunction
endpackage

// File: rtl/sme_lm_map.sv
module sme_lm_map
  import sme_pkg::*;
#(
  parameter int LM_WORDS = 40,
  parameter int AW       = 6,
  parameter int IXW      = 4
) (
  input  lm_region_e     region,
  input  logic [IXW-1:0] idx,
  output logic [AW-1:0]  addr
);
  localparam int K = LM_WORDS / 5;

  logic [AW-1:0] base;

  always_comb begin
    unique case (region)
      RG_IN:   base = AW'(0);
      RG_OUT:  base = AW'(K);
      RG_SIG:  base = AW'(2 * K);
      RG_PER:  base = AW'(3 * K);
      default: base = AW'(4 * K);
    endcase
    addr = base + AW'(idx);
  end
endmodule

// File: rtl/sme_divider.sv
module sme_divider
  import sme_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WIDE_W-1:0] dividend,
  input  logic [DATA_W-1:0] divisor,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] quot
);
  localparam int CW = $clog2(WIDE_W + 1);

  logic [DATA_W:0]   rem_q;
  logic [WIDE_W-1:0] dvd_q;
  logic [WIDE_W-1:0] acc_q;
  logic [DATA_W-1:0] dmag_q;
  logic              neg_q;
  logic [CW-1:0]     cnt_q;

  logic [DATA_W:0]   trial;
  logic              fits;

  always_comb begin
    trial = {rem_q[DATA_W-1:0], dvd_q[WIDE_W-1]};
    fits  = (trial >= {1'b0, dmag_q});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q  <= '0;
      dvd_q  <= '0;
      acc_q  <= '0;
      dmag_q <= '0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      busy   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        dvd_q  <= wide_mag(dividend);
        dmag_q <= word_mag(divisor);
        neg_q  <= dividend[WIDE_W-1] ^ divisor[DATA_W-1];
        rem_q  <= '0;
        acc_q  <= '0;
        cnt_q  <= '0;
        busy   <= 1'b1;
      end else if (busy) begin
        rem_q <= fits ? (trial - {1'b0, dmag_q}) : trial;
        dvd_q <= dvd_q << 1;
        acc_q <= {acc_q[WIDE_W-2:0], fits};
        cnt_q <= cnt_q + CW'(1);
        if (cnt_q == CW'(WIDE_W - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign quot = quot_fold(acc_q, neg_q);

  // R4: a finished restoring division leaves a remainder below the divisor.
  a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (rem_q < {1'b0, dmag_q}));
  // R4: a new division is never launched over a running one.
  a_r4_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  // R7: the zero factor case never reaches the divider.
  a_r7_no_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> (divisor != '0));
endmodule

// File: rtl/synapse_engine.sv
module synapse_engine
  import sme_pkg::*;
#(
  parameter int LM_WORDS = 40,
  parameter int SM_AW    = 32,
  localparam int LM_AW   = $clog2(LM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              done,
  output logic              div_err,
  output logic [LM_AW-1:0]  lm_addr,
  output logic              lm_we,
  output logic [31:0]       lm_wdata,
  input  logic [31:0]       lm_rdata,
  output logic              sm_req,
  output logic              sm_we,
  output logic [SM_AW-1:0]  sm_addr,
  output logic [31:0]       sm_wdata,
  input  logic [31:0]       sm_rdata,
  input  logic              sm_ready
);
  localparam int K   = LM_WORDS / 5;
  localparam int IXW = $clog2(K) + 1;

  eng_state_e        state_q;
  logic [IXW-1:0]    idx_q;
  logic [DATA_W-1:0] exc_q;
  logic [DATA_W-1:0] fac_q;
  logic [DATA_W-1:0] insz_q;
  logic [DATA_W-1:0] outsz_q;
  logic [SM_AW-1:0]  sm_addr_q;
  logic [DATA_W-1:0] sm_wdata_q;
  logic [DATA_W-1:0] sig_q;
  logic              err_q;

  // Named internal events.
  logic [DATA_W-1:0] idx_next;
  logic              in_last;
  logic              out_last;
  logic              p1_take;
  logic              p4_take;
  logic              div_start;
  logic              div_busy;
  logic              div_done;
  logic [DATA_W-1:0] div_quot;
  logic [WIDE_W-1:0] product;
  lm_region_e        map_region;
  logic [IXW-1:0]    map_idx;

  assign idx_next  = DATA_W'(idx_q) + DATA_W'(1);
  assign in_last   = (idx_next >= insz_q);
  assign out_last  = (idx_next >= outsz_q);
  assign p1_take   = (state_q == S_P1_SM) && sm_ready;
  assign p4_take   = (state_q == S_P4_SM) && sm_ready;
  assign product   = wide_product(exc_q, lm_rdata);
  assign div_start = (state_q == S_P2_MUL) && (fac_q != '0);

  always_comb begin
    map_region = RG_IN;
    map_idx    = idx_q;
    unique case (state_q)
      S_LDS:   begin
        map_region = RG_SCL;
        map_idx    = (int'(idx_q) >= SCL_COUNT) ? '0 : idx_q;
      end
      S_WB:    begin
        map_region = RG_SCL;
        map_idx    = IXW'(SCL_EXC);
      end
      S_P1_RD: map_region = RG_IN;
      S_P2_RD: map_region = RG_PER;
      S_P2_WR: map_region = RG_SIG;
      S_P3_RD: map_region = RG_SIG;
      S_P4_RA: map_region = RG_OUT;
      S_P4_RB: map_region = RG_SIG;
      default: map_idx    = '0;
    endcase
  end

  sme_lm_map #(
    .LM_WORDS(LM_WORDS),
    .AW      (LM_AW),
    .IXW     (IXW)
  ) u_map (
    .region(map_region),
    .idx   (map_idx),
    .addr  (lm_addr)
  );

  sme_divider u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (div_start),
    .dividend(product),
    .divisor (fac_q),
    .busy    (div_busy),
    .done    (div_done),
    .quot    (div_quot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      idx_q      <= '0;
      exc_q      <= '0;
      fac_q      <= '0;
      insz_q     <= '0;
      outsz_q    <= '0;
      sm_addr_q  <= '0;
      sm_wdata_q <= '0;
      sig_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start) begin
          idx_q   <= '0;
          state_q <= S_LDS;
        end
        S_LDS: begin
          unique case (int'(idx_q))
            SCL_EXC + 1:   exc_q   <= lm_rdata;
            SCL_FAC + 1:   fac_q   <= lm_rdata;
            SCL_INSZ + 1:  insz_q  <= lm_rdata;
            SCL_OUTSZ + 1: outsz_q <= lm_rdata;
            default: ;
          endcase
          if (int'(idx_q) == SCL_COUNT) state_q <= S_DISP;
          else idx_q <= idx_q + IXW'(1);
        end
        S_DISP: begin
          idx_q <= '0;
          if (insz_q != '0)       state_q <= S_P1_RD;
          else if (outsz_q != '0) state_q <= S_P2_RD;
          else                    state_q <= S_WB;
        end
        S_P1_RD:  state_q <= S_P1_ADR;
        S_P1_ADR: begin
          sm_addr_q <= lm_rdata[SM_AW-1:0];
          state_q   <= S_P1_SM;
        end
        S_P1_SM: if (sm_ready) begin
          exc_q <= exc_q + sm_rdata;
          if (in_last) begin
            idx_q   <= '0;
            state_q <= (outsz_q != '0) ? S_P2_RD : S_WB;
          end else begin
            idx_q   <= idx_q + IXW'(1);
            state_q <= S_P1_RD;
          end
        end
        S_P2_RD:  state_q <= S_P2_MUL;
        S_P2_MUL: begin
          if (fac_q == '0) begin
            sig_q   <= '0;
            err_q   <= 1'b1;
            state_q <= S_P2_WR;
          end else begin
            state_q <= S_P2_DIV;
          end
        end
        S_P2_DIV: if (div_done) begin
          sig_q   <= div_quot;
          state_q <= S_P2_WR;
        end
        S_P2_WR: begin
          if (out_last) begin
            idx_q   <= '0;
            state_q <= S_P3_RD;
          end else begin
            idx_q   <= idx_q + IXW'(1);
            state_q <= S_P2_RD;
          end
        end
        S_P3_RD:  state_q <= S_P3_ACC;
        S_P3_ACC: begin
          exc_q <= exc_q - lm_rdata;
          if (out_last) begin
            idx_q   <= '0;
            state_q <= S_P4_RA;
          end else begin
            idx_q   <= idx_q + IXW'(1);
            state_q <= S_P3_RD;
          end
        end
        S_P4_RA: state_q <= S_P4_RB;
        S_P4_RB: begin
          sm_addr_q <= lm_rdata[SM_AW-1:0];
          state_q   <= S_P4_CAP;
        end
        S_P4_CAP: begin
          sm_wdata_q <= lm_rdata;
          state_q    <= S_P4_SM;
        end
        S_P4_SM: if (sm_ready) begin
          if (out_last) state_q <= S_WB;
          else begin
            idx_q   <= idx_q + IXW'(1);
            state_q <= S_P4_RA;
          end
        end
        S_WB:    state_q <= S_DONE;
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign lm_we    = (state_q == S_P2_WR) || (state_q == S_WB);
  assign lm_wdata = (state_q == S_WB) ? exc_q : sig_q;
  assign sm_req   = (state_q == S_P1_SM) || (state_q == S_P4_SM);
  assign sm_we    = (state_q == S_P4_SM);
  assign sm_addr  = sm_addr_q;
  assign sm_wdata = sm_wdata_q;
  assign done     = (state_q == S_DONE);
  assign div_err  = err_q;

  // R9: the completion pulse lasts one clock.
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: completion always follows the excitation store.
  a_r9_done_after_store: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(lm_we) && ($past(lm_addr) == LM_AW'(4 * K)));
  // R10: a stalled shared request holds still.
  a_r10_sm_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && !sm_ready) |=> sm_req && $stable(sm_addr) && $stable(sm_we)
                              && $stable(sm_wdata));
  // R11: local writes land only in the signal table or the excitation word.
  a_r11_lm_write_region: assert property (@(posedge clk) disable iff (!rst_n)
    lm_we |-> ((lm_addr >= LM_AW'(2 * K)) && (lm_addr < LM_AW'(3 * K)))
              || (lm_addr == LM_AW'(4 * K)));
  // R7: the divide error flag is sticky.
  a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    div_err |=> div_err);
  // R8: a gather request only occurs for an index below the gather count.
  a_r8_gather_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && !sm_we) |-> (DATA_W'(idx_q) < insz_q));
  // R6: a scatter request only occurs for an index below the scatter count.
  a_r6_scatter_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_req && sm_we) |-> (DATA_W'(idx_q) < outsz_q));
  // R4: the divider only runs during the scaling phase.
  a_r4_div_in_phase: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> (state_q == S_P2_DIV));
endmodule

// File: tb/synapse_engine_bench.sv
module synapse_engine_bench;
  localparam int LM_WORDS = 40;
  localparam int K        = LM_WORDS / 5;
  localparam int LM_AW    = $clog2(LM_WORDS);
  localparam int SM_WORDS = 64;
  localparam int SMI      = $clog2(SM_WORDS);
  localparam int SM_AW    = 32;
  localparam int LOGN     = 256;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n, start, done, div_err;
  logic [LM_AW-1:0] lm_addr;
  logic             lm_we;
  logic [31:0]      lm_wdata, lm_rdata;
  logic             sm_req, sm_we, sm_ready;
  logic [SM_AW-1:0] sm_addr;
  logic [31:0]      sm_wdata, sm_rdata;

  synapse_engine #(.LM_WORDS(LM_WORDS), .SM_AW(SM_AW)) u_synapse_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done), .div_err(div_err),
    .lm_addr(lm_addr), .lm_we(lm_we), .lm_wdata(lm_wdata), .lm_rdata(lm_rdata),
    .sm_req(sm_req), .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata),
    .sm_rdata(sm_rdata), .sm_ready(sm_ready)
  );

  logic [31:0] lm_mem [LM_WORDS];
  logic [31:0] sm_mem [SM_WORDS];
  logic [31:0] wlog   [LOGN];
  int rd_total = 0, wr_total = 0, done_total = 0;
  int total = 0, bad = 0;
  bit fast_ready = 1'b0;

  // Memory models: local memory with one clock read latency, shared memory
  // answering in the granted clock.
  always @(posedge clk) begin
    if (lm_we && int'(lm_addr) < LM_WORDS) lm_mem[lm_addr] <= lm_wdata;
    lm_rdata <= (int'(lm_addr) < LM_WORDS) ? lm_mem[lm_addr] : 32'h0;
    if (sm_req && sm_ready) begin
      if (sm_we) begin
        sm_mem[sm_addr[SMI-1:0]] <= sm_wdata;
        wlog[wr_total % LOGN]   <= sm_addr;
        wr_total                <= wr_total + 1;
      end else begin
        rd_total <= rd_total + 1;
      end
    end
    if (done) done_total <= done_total + 1;
  end
  assign sm_rdata = sm_mem[sm_addr[SMI-1:0]];

  initial sm_ready = 1'b0;
  always @(negedge clk) sm_ready <= fast_ready || ($urandom_range(2, 0) != 0);

  // Stimulus for one run.
  int in_t [K];
  int out_t[K];
  int per_t[K];
  int sig0 [K];
  int sm0  [SM_WORDS];
  int exc0, fac0, insz, outsz;
  bit err_exp = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int mixed_word();
    int sel;
    sel = int'($urandom_range(2, 0));
    if (sel == 0) return int'($urandom);
    if (sel == 1) return int'($urandom_range(2000, 0)) - 1000;
    return int'($urandom_range(20, 0)) - 10;
  endfunction

  task automatic rand_case(input int ni, input int no);
    insz  = ni;
    outsz = no;
    for (int i = 0; i < K; i++) begin
      in_t[i]  = int'($urandom_range(SM_WORDS - 1, 0));
      out_t[i] = int'($urandom_range(SM_WORDS - 1, 0));
      per_t[i] = mixed_word();
      sig0[i]  = int'($urandom);
    end
    for (int j = 0; j < SM_WORDS; j++) sm0[j] = mixed_word();
    exc0 = mixed_word();
    do fac0 = mixed_word(); while (fac0 == 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n   = 1'b1;
    err_exp = 1'b0;
  endtask

  task automatic run_case(input bit poke);
    int exc1, excf, rd0, wr0, dn0, nmis;
    int sig_e[K];
    int sm_e [SM_WORDS];
    longint prod;
    // R2: table and scalar placement
    for (int i = 0; i < K; i++) begin
      lm_mem[i]       = in_t[i];
      lm_mem[K + i]   = out_t[i];
      lm_mem[2*K + i] = sig0[i];
      lm_mem[3*K + i] = per_t[i];
    end
    lm_mem[4*K]     = exc0;
    lm_mem[4*K + 1] = fac0;
    lm_mem[4*K + 2] = insz;
    lm_mem[4*K + 3] = outsz;
    for (int j = 0; j < SM_WORDS; j++) sm_mem[j] = sm0[j];
    // Expected results.
    exc1 = exc0;
    for (int i = 0; i < insz; i++) exc1 += sm0[in_t[i]];
    excf = exc1;
    for (int i = 0; i < K; i++) sig_e[i] = sig0[i];
    for (int i = 0; i < outsz; i++) begin
      if (fac0 == 0) sig_e[i] = 0;
      else begin
        prod     = longint'(exc1) * longint'(per_t[i]);
        sig_e[i] = int'(prod / longint'(fac0));
      end
      excf -= sig_e[i];
    end
    if (fac0 == 0 && outsz > 0) err_exp = 1'b1;
    for (int j = 0; j < SM_WORDS; j++) sm_e[j] = sm0[j];
    for (int i = 0; i < outsz; i++) sm_e[out_t[i]] = sig_e[i];
    rd0 = rd_total; wr0 = wr_total; dn0 = done_total;

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (12) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);

    check(lm_mem[4*K] == excf, "R5", "stored excitation", lm_mem[4*K], excf);
    for (int i = 0; i < K; i++)
      check(lm_mem[2*K + i] == sig_e[i], (i < outsz) ? "R4" : "R11",
            "signal entry", int'(lm_mem[2*K + i]), sig_e[i]);
    nmis = 0;
    for (int j = 0; j < SM_WORDS; j++) if (sm_mem[j] != sm_e[j]) nmis++;
    check(nmis == 0, "R6", "shared words differing", nmis, 0);
    check(rd_total - rd0 == insz, (insz > 0) ? "R3" : "R8", "shared reads",
          rd_total - rd0, insz);
    check(wr_total - wr0 == outsz, (outsz > 0) ? "R6" : "R8", "shared writes",
          wr_total - wr0, outsz);
    for (int i = 0; i < outsz; i++)
      check(wlog[(wr0 + i) % LOGN] == out_t[i], "R6", "scatter order",
            wlog[(wr0 + i) % LOGN], out_t[i]);
    check(div_err == err_exp, "R7", "divide error flag", div_err, err_exp);
    @(negedge clk);
    check(done == 1'b0, "R9", "done width", done, 0);
    repeat (3) @(negedge clk);
    check(done_total - dn0 == 1, "R9", "done pulses per run",
          done_total - dn0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R9 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A11));
    rst_n = 1'b0;
    start = 1'b0;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && sm_req == 1'b0 && lm_we == 1'b0, "R1",
          "outputs in reset", {done, sm_req, lm_we}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(div_err == 1'b0, "R1", "div_err after reset", div_err, 0);
    check(sm_req == 1'b0 && lm_we == 1'b0, "R1", "idle requests",
          {sm_req, lm_we}, 0);

    // R8 + R4: no gather, negative excitation, truncation toward zero.
    rand_case(0, 3);
    exc0 = -7; per_t[0] = 3; per_t[1] = 5; per_t[2] = -1; fac0 = 2;
    run_case(1'b0);
    // R8: gather only.
    rand_case(5, 0);
    run_case(1'b0);
    // R8: both phases empty.
    rand_case(0, 0);
    run_case(1'b0);
    // R3/R6: largest counts with ready held high.
    fast_ready = 1'b1;
    rand_case(K - 1, K - 1);
    run_case(1'b0);
    fast_ready = 1'b0;
    // R9: start pulsed during a run is ignored.
    rand_case(4, 4);
    run_case(1'b1);
    // R7: zero factor, then the flag stays across a good run, then reset clears.
    rand_case(2, 3);
    fac0 = 0;
    run_case(1'b0);
    rand_case(3, 2);
    run_case(1'b0);
    do_reset();
    @(negedge clk);
    check(div_err == 1'b0, "R7", "flag cleared by reset", div_err, 0);
    // Factor of minus one with large operands.
    rand_case(K - 1, 2);
    fac0 = -1; per_t[0] = 32'h7FFF_FFFF; per_t[1] = 32'h8000_0000;
    run_case(1'b0);

    // Random runs.
    for (int n = 0; n < 25; n++) begin
      fast_ready = ($urandom_range(3, 0) == 0);
      rand_case(int'($urandom_range(K - 1, 0)), int'($urandom_range(K - 1, 0)));
      run_case(1'b0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule